// File: doc/BRIEF.md
# Cascaded Switch-Chain Programmer

This block is the host-side master that loads a row of cascaded serial switch-control devices. Each device holds sixteen channels. Its serial input is clocked on the rising edge of a shift clock. Its serial output feeds the next device. A separate active-low strobe copies the shifted pattern into the switch latches, and an active-high clear opens every switch at once. The master takes a parallel word holding one bit per channel for the whole chain, plus a start strobe. It then produces the shift clock, the serial data, the commit strobe and the clear line, all derived from the system clock.

Bit `d*CH_PER_DEV + c` of the word is the wanted state of channel `c` on device `d`, where 1 means closed and 0 means open. Device 0 is the one whose serial input is driven by this block. The word is sent most significant bit first, so after a full load the top bit sits on the highest channel of the last device in the chain.

Every timing limit of the devices is given as a parameter in nanoseconds. The block turns each one into a whole number of system clocks by rounding up, with a floor of one. The limits covered are the shift-clock half period, the data-to-strobe setup, the strobe width and the clear width.

Top module: `swchain_prog`

## Requirements
- R1: An accepted start produces exactly NUM_DEV*CH_PER_DEV rising edges on `sw_clk`, one per pattern bit.
- R2: Bits go out from `pattern` bit NBITS-1 down to bit 0. After the update, channel c of device d shows `pattern[d*CH_PER_DEV+c]`, with 1 meaning closed.
- R3: During a load, every high phase of `sw_clk` lasts HALF_CYC system clocks. Every low phase between two rising edges also lasts HALF_CYC. HALF_CYC is ceil(SCLK_HALF_NS/SYS_CLK_NS).
- R4: `sw_din` changes only while `sw_clk` is low. It holds its value through every high phase.
- R5: `sw_le` stays high while bits are shifted and between transactions. `sw_clk` idles low.
- R6: After the last falling edge of `sw_clk`, `sw_le` stays high for SETUP_CYC clocks. It then goes low for exactly LEW_CYC clocks, once per load.
- R7: `busy` is high from the clock after an accepted start until `sw_le` returns high. `done` is a single-cycle pulse in the cycle `sw_le` returns high, and `busy` is low in that cycle.
- R8: A start that arrives while `busy` is high is ignored. The pattern and the edge count of the running load are unchanged.
- R9: A clear request drives `sw_clr` high for CLRW_CYC clocks, counted from the last cycle `clear_req` is high. During that time `sw_le` is high and `sw_clk` is low, and all channels open.
- R10: A clear request during a load aborts it with no strobe pulse and no `done`. A clear and a start in the same idle cycle start the clear only.
- R11: While in reset, `busy`, `done`, `sw_clk` and `sw_clr` are low and `sw_le` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load of `pattern` (taken only when idle) |
| pattern | input | NUM_DEV*CH_PER_DEV | Wanted channel states, 1 = closed |
| clear_req | input | 1 | Request a clear pulse; aborts a running load |
| busy | output | 1 | A load or clear is in progress |
| done | output | 1 | One-cycle pulse when a load has been committed |
| sw_clk | output | 1 | Shift clock to the chain |
| sw_din | output | 1 | Serial data to the first device |
| sw_le | output | 1 | Commit strobe, active low |
| sw_clr | output | 1 | Clear line, active high |

## Verification
The bench drives a cycle model of the cascaded shift registers and transparent latches from the block's outputs. It loads patterns chosen to expose different faults:
- all-ones and all-zeros, which show stuck bits;
- a lone top bit and a lone bottom bit, which show whether the bit order is reversed or off by one at the device boundary;
- an alternating pattern, which shows bits that are skipped or doubled;
- seeded random words, for general coverage.

Other stimuli target the control paths: a start issued in the middle of a load, a clear from idle, a clear that aborts a load, and a clear that arrives together with a start. Together these separate the ignore, abort and priority rules from the normal commit path.

// File: rtl/swchain_pkg.sv
package swchain_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LO    = 3'd1,
      ST_HI    = 3'd2,
      ST_SETUP = 3'd3,
      ST_LEL   = 3'd4,
      ST_CLR   = 3'd5
   } seq_st_t;

   // Convert a minimum duration in ns to system clocks, rounded up, at least 1.
   function automatic int cyc_of(input int dur_ns, input int per_ns);
      int c;
      c = (dur_ns + per_ns - 1) / per_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/swchain_timer.sv
module swchain_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("swchain_timer: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/swchain_serializer.sv
module swchain_serializer #(
   parameter int NBITS     = 32,
   parameter int SER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [NBITS-1:0] pat_i,
   input  logic             adv_i,
   output logic             bit_o,
   output logic             last_o
);

   localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NBITS - 1);

   logic [IDX_W-1:0] idx_q;

   generate
      if (NBITS < 2) begin : g_bad_n
         $error("swchain_serializer: NBITS must be at least 2");
      end
      if (SER_STYLE != 0 && SER_STYLE != 1) begin : g_bad_style
         $error("swchain_serializer: SER_STYLE must be 0 or 1");
      end
   endgenerate

   // Remaining-bit index shared by both variants.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (load_i) begin
         idx_q <= TOP_IDX;
      end else if (adv_i && idx_q != '0) begin
         idx_q <= idx_q - 1'b1;
      end
   end

   assign last_o = (idx_q == '0);

   generate
      if (SER_STYLE == 0) begin : g_shift
         // Shifting variant: top bit of a left-moving register drives the line.
         logic [NBITS-1:0] sreg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sreg_q <= '0;
            end else if (load_i) begin
               sreg_q <= pat_i;
            end else if (adv_i) begin
               sreg_q <= {sreg_q[NBITS-2:0], 1'b0};
            end
         end
         assign bit_o = sreg_q[NBITS-1];
      end else begin : g_index
         // Indexed variant: pattern held still, a mux picks the current bit.
         logic [NBITS-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (load_i) begin
               hold_q <= pat_i;
            end
         end
         assign bit_o = hold_q[idx_q];
      end
   endgenerate

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> !last_o); // R1

   AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && adv_i)); // R8

endmodule

// File: rtl/swchain_prog.sv
module swchain_prog
   import swchain_pkg::*;
#(
   parameter int NUM_DEV      = 2,
   parameter int CH_PER_DEV   = 16,
   parameter int SYS_CLK_NS   = 10,
   parameter int SCLK_HALF_NS = 25,
   parameter int LE_SETUP_NS  = 25,
   parameter int LE_WIDTH_NS  = 12,
   parameter int CLR_WIDTH_NS = 55,
   parameter int SER_STYLE    = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NUM_DEV*CH_PER_DEV-1:0] pattern,
   input  logic                          clear_req,
   output logic                          busy,
   output logic                          done,
   output logic                          sw_clk,
   output logic                          sw_din,
   output logic                          sw_le,
   output logic                          sw_clr
);

   localparam int NBITS     = NUM_DEV * CH_PER_DEV;
   localparam int HALF_CYC  = cyc_of(SCLK_HALF_NS, SYS_CLK_NS);
   localparam int SETUP_CYC = cyc_of(LE_SETUP_NS, SYS_CLK_NS);
   localparam int LEW_CYC   = cyc_of(LE_WIDTH_NS, SYS_CLK_NS);
   localparam int CLRW_CYC  = cyc_of(CLR_WIDTH_NS, SYS_CLK_NS);
   localparam int TMR_MAX   = max4(HALF_CYC, SETUP_CYC, LEW_CYC, CLRW_CYC);
   localparam int TMR_W     = (TMR_MAX > 1) ? $clog2(TMR_MAX) : 1;

   localparam logic [TMR_W-1:0] HALF_LD  = TMR_W'(HALF_CYC - 1);
   localparam logic [TMR_W-1:0] SETUP_LD = TMR_W'(SETUP_CYC - 1);
   localparam logic [TMR_W-1:0] LEW_LD   = TMR_W'(LEW_CYC - 1);
   localparam logic [TMR_W-1:0] CLRW_LD  = TMR_W'(CLRW_CYC - 1);

   // Elaboration-time parameter checks against the devices' minimum timings.
   generate
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("swchain_prog: NUM_DEV must be at least 1");
      end
      if (CH_PER_DEV < 2) begin : g_bad_ch
         $error("swchain_prog: CH_PER_DEV must be at least 2");
      end
      if (SYS_CLK_NS < 1) begin : g_bad_per
         $error("swchain_prog: SYS_CLK_NS must be positive");
      end
      if (SCLK_HALF_NS < 25) begin : g_bad_half
         $error("swchain_prog: shift clock half period below 25 ns (20 MHz)");
      end
      if (LE_SETUP_NS < 25) begin : g_bad_setup
         $error("swchain_prog: strobe setup below 25 ns");
      end
      if (LE_WIDTH_NS < 12) begin : g_bad_lew
         $error("swchain_prog: strobe width below 12 ns");
      end
      if (CLR_WIDTH_NS < 55) begin : g_bad_clrw
         $error("swchain_prog: clear width below 55 ns");
      end
   endgenerate

   seq_st_t          st_q, st_d;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             ser_load, ser_adv, ser_bit, ser_last;
   logic             done_d;
   logic             clk_q, le_q, clr_q, done_q;

   swchain_timer #(.CNT_W(TMR_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   swchain_serializer #(.NBITS(NBITS), .SER_STYLE(SER_STYLE)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ser_load),
      .pat_i  (pattern),
      .adv_i  (ser_adv),
      .bit_o  (ser_bit),
      .last_o (ser_last)
   );

   // Sequencer: clear has priority over everything, including a running load.
   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ser_load = 1'b0;
      ser_adv  = 1'b0;
      done_d   = 1'b0;
      if (clear_req) begin
         st_d     = ST_CLR;
         tmr_load = 1'b1;
         tmr_val  = CLRW_LD;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_d     = ST_LO;
                  tmr_load = 1'b1;
                  tmr_val  = HALF_LD;
                  ser_load = 1'b1;
               end
            end
            ST_LO: begin
               if (tmr_zero) begin
                  st_d     = ST_HI;
                  tmr_load = 1'b1;
                  tmr_val  = HALF_LD;
               end
            end
            ST_HI: begin
               if (tmr_zero) begin
                  tmr_load = 1'b1;
                  if (ser_last) begin
                     st_d    = ST_SETUP;
                     tmr_val = SETUP_LD;
                  end else begin
                     st_d    = ST_LO;
                     tmr_val = HALF_LD;
                     ser_adv = 1'b1;
                  end
               end
            end
            ST_SETUP: begin
               if (tmr_zero) begin
                  st_d     = ST_LEL;
                  tmr_load = 1'b1;
                  tmr_val  = LEW_LD;
               end
            end
            ST_LEL: begin
               if (tmr_zero) begin
                  st_d   = ST_IDLE;
                  done_d = 1'b1;
               end
            end
            ST_CLR: begin
               if (tmr_zero) begin
                  st_d = ST_IDLE;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   // State and registered pin drivers, decoded from the next state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         clk_q  <= 1'b0;
         le_q   <= 1'b1;
         clr_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         clk_q  <= (st_d == ST_HI);
         le_q   <= (st_d != ST_LEL);
         clr_q  <= (st_d == ST_CLR);
         done_q <= done_d;
      end
   end

   assign busy   = (st_q != ST_IDLE);
   assign done   = done_q;
   assign sw_clk = clk_q;
   assign sw_din = ser_bit;
   assign sw_le  = le_q;
   assign sw_clr = clr_q;

   AST_LE_HIGH_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clk |-> sw_le); // R5

   AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clk |-> $stable(sw_din)); // R4

   AST_DONE_ON_LE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(sw_le)); // R7

   AST_LE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_le |-> busy); // R7

   AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |-> (sw_le && !sw_clk)); // R9

   AST_CLR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> !done); // R10

endmodule

// File: tb/sim_swchain_prog.sv
module sim_swchain_prog;

   localparam int NDEV = 2;
   localparam int NCH  = 16;
   localparam int NB   = NDEV * NCH;
   localparam int PER  = 10;

   function automatic int ceil_cyc(input int ns);
      return (ns + PER - 1) / PER;
   endfunction

   localparam int HALF = ceil_cyc(25);
   localparam int SETC = ceil_cyc(25);
   localparam int LEWC = ceil_cyc(12);
   localparam int CLRC = ceil_cyc(55);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          clear_req = 1'b0;
   logic [NB-1:0] pattern = '0;
   logic          busy, done, sw_clk, sw_din, sw_le, sw_clr;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   swchain_prog #(.NUM_DEV(NDEV), .CH_PER_DEV(NCH), .SYS_CLK_NS(PER)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
      .clear_req(clear_req), .busy(busy), .done(done), .sw_clk(sw_clk),
      .sw_din(sw_din), .sw_le(sw_le), .sw_clr(sw_clr)
   );

   // Model of the cascaded chain: index d*NCH+c is device d, channel c.
   logic [NB-1:0] m_chain = '0;
   logic [NB-1:0] m_latch = '0;
   logic p_clk = 1'b0, p_le = 1'b1, p_din = 1'b0, p_clr = 1'b0, p_done = 1'b0;
   int rises, hi_run, lo_run, since_fall, le_run, clr_run;
   int bad_hi, bad_lo, din_chg, le_shift, bad_setup, bad_lew, le_falls;
   int bad_clrw, clr_seen, done_cnt, bad_done, le_nobusy;
   bit lo_valid;

   task automatic mon_reset();
      rises = 0; hi_run = 0; lo_run = 0; since_fall = 0; le_run = 0; clr_run = 0;
      bad_hi = 0; bad_lo = 0; din_chg = 0; le_shift = 0; bad_setup = 0;
      bad_lew = 0; le_falls = 0; bad_clrw = 0; clr_seen = 0; done_cnt = 0;
      bad_done = 0; le_nobusy = 0; lo_valid = 0;
   endtask

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (sw_clr) begin
            m_chain = '0;
            m_latch = '0;
         end else begin
            if (sw_clk && !p_clk) m_chain = {m_chain[NB-2:0], sw_din};
            if (!sw_le) m_latch = m_chain;
         end
         if (sw_clk && !p_clk) begin
            rises++;
            if (lo_valid && lo_run != HALF) bad_lo++;
            hi_run = 1;
         end else if (sw_clk) begin
            hi_run++;
         end
         if (!sw_clk && p_clk) begin
            if (hi_run != HALF) bad_hi++;
            lo_run = 1; lo_valid = 1; since_fall = 1;
         end else if (!sw_clk) begin
            lo_run++;
            if (sw_le) since_fall++;
         end
         if (sw_clk && sw_din != p_din) din_chg++;
         if (!sw_le && (sw_clk || rises < NB)) le_shift++;
         if (!sw_le && !busy) le_nobusy++;
         if (!sw_le && p_le) begin
            le_falls++;
            if (since_fall != SETC) bad_setup++;
         end
         if (!sw_le) le_run++;
         if (sw_le && !p_le) begin
            if (le_run != LEWC) bad_lew++;
            le_run = 0;
         end
         if (sw_clr) clr_run++;
         if (!sw_clr && p_clr) begin
            clr_seen++;
            if (clr_run != CLRC) bad_clrw++;
            clr_run = 0;
         end
         if (done) begin
            done_cnt++;
            if (!(sw_le && !p_le) || busy || p_done) bad_done++;
         end
      end
      p_clk = sw_clk; p_le = sw_le; p_din = sw_din; p_clr = sw_clr; p_done = done;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wait_done();
      int n = 0;
      while (done_cnt == 0 && n < 5000) begin
         @(posedge clk);
         n++;
      end
   endtask

   task automatic do_load(input logic [NB-1:0] p, input bit poke);
      mon_reset();
      @(posedge clk); #1 start = 1'b1; pattern = p;
      @(posedge clk); #1 start = 1'b0;
      chk(busy == 1'b1, "R7", "busy after start", NB'(busy), NB'(1));
      if (poke) begin
         repeat (20) @(posedge clk);
         #1 start = 1'b1; pattern = ~p;
         @(posedge clk); #1 start = 1'b0;
      end
      wait_done();
      repeat (3) @(negedge clk);
      chk(m_latch == p, poke ? "R8" : "R2", "latched pattern", m_latch, p);
      chk(rises == NB, poke ? "R8" : "R1", "clock edges", NB'(rises), NB'(NB));
      chk(bad_hi == 0 && bad_lo == 0, "R3", "phase widths bad", NB'(bad_hi + bad_lo), '0);
      chk(din_chg == 0, "R4", "din change in high", NB'(din_chg), '0);
      chk(le_shift == 0 && sw_le && !sw_clk, "R5", "strobe during shift", NB'(le_shift), '0);
      chk(bad_setup == 0 && bad_lew == 0 && le_falls == 1, "R6", "strobe timing",
          NB'(bad_setup + bad_lew), '0);
      chk(done_cnt == 1 && bad_done == 0 && le_nobusy == 0 && !busy, "R7",
          "done pulse count", NB'(done_cnt), NB'(1));
   endtask

   task automatic do_clear(input bit with_start);
      mon_reset();
      @(posedge clk); #1 clear_req = 1'b1; start = with_start; pattern = '1;
      @(posedge clk); #1 clear_req = 1'b0; start = 1'b0;
      repeat (CLRC + 4) @(posedge clk);
      @(negedge clk);
      chk(clr_seen == 1 && bad_clrw == 0, "R9", "clear width", NB'(clr_run), NB'(CLRC));
      chk(m_latch == '0, "R9", "channels after clear", m_latch, '0);
      if (with_start)
         chk(rises == 0 && done_cnt == 0 && !busy, "R10", "start beside clear", NB'(rises), '0);
   endtask

   initial begin
      logic [NB-1:0] rp;
      void'($urandom(32'd20240517));
      mon_reset();
      repeat (3) @(negedge clk);
      chk(!busy && !done && !sw_clk && sw_le && !sw_clr, "R11", "reset levels",
          NB'({busy, done, sw_clk, sw_le, sw_clr}), NB'(5'b00010));
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);

      do_load('1, 1'b0);
      do_load('0, 1'b0);
      do_load(NB'(1) << (NB - 1), 1'b0);
      do_load(NB'(1), 1'b0);
      do_load({(NB/2){2'b10}}, 1'b0);
      do_load(NB'(1) << NCH, 1'b0);
      for (int k = 0; k < 6; k++) begin
         for (int i = 0; i < NB; i++) rp[i] = 1'($urandom & 1);
         do_load(rp, 1'b0);
      end
      for (int i = 0; i < NB; i++) rp[i] = 1'($urandom & 1);
      do_load(rp, 1'b1);

      do_clear(1'b0);
      do_load(32'hA5C3_0F81, 1'b0);
      do_clear(1'b1);

      // Abort a running load with a clear (R10).
      mon_reset();
      @(posedge clk); #1 start = 1'b1; pattern = 32'h1234_ABCD;
      @(posedge clk); #1 start = 1'b0;
      repeat (25) @(posedge clk);
      #1 clear_req = 1'b1;
      @(posedge clk); #1 clear_req = 1'b0;
      repeat (CLRC + 6) @(posedge clk);
      @(negedge clk);
      chk(le_falls == 0 && done_cnt == 0 && !busy, "R10", "abort strobe and done",
          NB'(le_falls + done_cnt), '0);
      chk(m_latch == '0 && clr_seen == 1, "R10", "channels after abort", m_latch, '0);

      for (int i = 0; i < NB; i++) rp[i] = 1'($urandom & 1);
      do_load(rp, 1'b0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule